// File: doc/BRIEF.md
# Serial DAC Daisy-Chain Interface

This block is the digital front end of a current-output converter. It takes a three-wire serial stream: a serial clock, a data line and an active-low frame strobe. It assembles 16-bit words from that stream and keeps the decoded data code in a parallel register that feeds the converter core. The serial pins are oversampled by a faster system clock. Each pin passes through a two-flop synchronizer, and edges are detected in the system-clock domain. This allows serial clocks up to one quarter of the system clock rate.

A frame opens when the strobe goes low. On each active serial clock edge that follows, one bit enters the shift register, most significant bit first. When the strobe returns high after a complete frame, the two top bits are decoded as a control field. Either the lower bits are transferred, left-justified, into the parallel code register, or the capture edge is moved from falling to rising. The serial output presents the oldest bit of the shift register and changes on the edge opposite to the capture edge. Several devices can therefore be chained, each seeing the previous word while a new one is shifted in.

The frame controller has three states. In ST_IDLE the strobe is high. In ST_SHIFT fewer than 16 bits have been taken. In ST_FULL at least 16 bits have been taken. Its transitions are as follows:
- ST_IDLE to ST_SHIFT when the synchronized strobe is low.
- ST_SHIFT to ST_FULL when the 16th bit is taken.
- ST_SHIFT to ST_IDLE when the strobe rises early. This is the discard transition.
- ST_FULL to ST_IDLE when the strobe rises. This is the commit transition.

Top module: `dac_serial_link`

## Requirements
- R1: After power-on reset, the code output and the serial output are 0, and bits are taken on the falling serial clock edge.
- R2: A bit is taken from the data line only on an active serial clock edge while the strobe is low. Serial clock edges while the strobe is high change neither the code output nor the serial output.
- R3: Bits enter MSB first. The control field is frame bits 15:14. Control codes 00, 01 and 10 load the code output from frame bits 13 downward, left-justified, CODE_W bits wide. With CODE_W = 12, frame bits 1:0 are dropped.
- R4: The code output changes only following a rising edge of the synchronized strobe. This gives a double-buffered update.
- R5: Control code 11 switches capture to the rising serial clock edge and leaves the code output unchanged. Capture stays on the rising edge until reset.
- R6: The serial output changes only on the serial clock edge opposite to the capture edge. After each such edge it equals the bit taken 15 captures before the most recent one, so a word reappears at the output 16 captures later.
- R7: If the strobe rises after fewer than 16 bits, the frame is discarded and the code output keeps its value.
- R8: If the strobe rises after more than 16 bits, the last 16 bits taken form the frame.
- R9: An active serial clock edge detected in the same system clock cycle as the strobe rise is not taken.
- R10: The code output reflects a committed frame within four system clock cycles of the strobe pin rising.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| sclk_i | input | 1 | Serial clock pin |
| sdin_i | input | 1 | Serial data pin |
| sync_n_i | input | 1 | Active-low frame strobe pin |
| sdo_o | output | 1 | Serial data output for daisy-chaining |
| code_o | output | CODE_W | Parallel converter code |

## Verification
The strobe rise and a capture edge can be detected in the same system clock cycle. This matters when the last clock edge of a frame and the strobe release reach the pins in the same time step. The bench provokes the case by driving the 16th active serial clock edge and the strobe rise together. It judges the result at the ports: the frame holds only 15 bits, so the code output must keep its previous value, and the serial output must not advance. Ordinary frames, with the strobe released a few system clocks after the last edge, are checked alongside so that the difference is visible.

// File: rtl/dsl_pkg.sv
package dsl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_FULL  = 2'd2
    } link_state_e;

    localparam logic [1:0] CTRL_EDGE_RISE = 2'b11;
endpackage

// File: rtl/dsl_sync.sv
module dsl_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d_i;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/dsl_edge.sv
module dsl_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev;
    assign fall_o = ~lvl_i & prev;
endmodule

// File: rtl/dsl_frame_fsm.sv
module dsl_frame_fsm
    import dsl_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_s,
    input  logic              sdin_s,
    input  logic              cap_edge,
    input  logic              out_edge,
    output logic [CODE_W-1:0] code_o,
    output logic              sdo_o,
    output logic              rise_mode_o,
    output link_state_e       state_o
);
    localparam int CNT_W = $clog2(FRAME_W);
    localparam int DATA_MSB = FRAME_W - 3;

    link_state_e        state, nxt;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   bit_cnt;
    logic               take, last_bit, commit;

    assign take     = cap_edge & ~sync_s;
    assign last_bit = (bit_cnt == CNT_W'(FRAME_W - 1));
    assign commit   = (state == ST_FULL) & sync_s;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (!sync_s) nxt = ST_SHIFT;
            ST_SHIFT: begin
                if (sync_s)                nxt = ST_IDLE;
                else if (take && last_bit) nxt = ST_FULL;
            end
            ST_FULL:  if (sync_s) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // shift register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else begin
            if (take) shreg <= {shreg[FRAME_W-2:0], sdin_s};
            if (sync_s)                         bit_cnt <= '0;
            else if (take && state != ST_FULL)  bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // outputs: serial out, parallel code, capture-edge mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_o      <= '0;
            sdo_o       <= 1'b0;
            rise_mode_o <= 1'b0;
        end else begin
            if (out_edge) sdo_o <= shreg[FRAME_W-1];
            if (commit) begin
                if (shreg[FRAME_W-1 -: 2] == CTRL_EDGE_RISE) rise_mode_o <= 1'b1;
                else code_o <= shreg[DATA_MSB -: CODE_W];
            end
        end
    end

    assign state_o = state;
endmodule

// File: rtl/dac_serial_link.sv
module dac_serial_link
    import dsl_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int FRAME_W = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sdin_i,
    input  logic              sync_n_i,
    output logic              sdo_o,
    output logic [CODE_W-1:0] code_o
);
    localparam int PIN_N = 3;

    logic [PIN_N-1:0] pins_s;
    logic             sclk_s, sdin_s, sync_s;
    logic             sclk_rise, sclk_fall;
    logic             cap_edge, out_edge, rise_mode;
    link_state_e      link_state;

    dsl_sync #(.W(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({sync_n_i, sdin_i, sclk_i}),
        .q_o(pins_s)
    );

    assign sclk_s = pins_s[0];
    assign sdin_s = pins_s[1];
    assign sync_s = pins_s[2];

    dsl_edge #(.RST_VAL(1'b0)) u_sclk_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(sclk_s),
        .rise_o(sclk_rise), .fall_o(sclk_fall)
    );

    assign cap_edge = rise_mode ? sclk_rise : sclk_fall;
    assign out_edge = rise_mode ? sclk_fall : sclk_rise;

    dsl_frame_fsm #(.FRAME_W(FRAME_W), .CODE_W(CODE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .sync_s(sync_s), .sdin_s(sdin_s),
        .cap_edge(cap_edge), .out_edge(out_edge),
        .code_o(code_o), .sdo_o(sdo_o),
        .rise_mode_o(rise_mode), .state_o(link_state)
    );
endmodule

// File: rtl/dsl_checker.sv
module dsl_checker
    import dsl_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk_s,
    input logic              sync_s,
    input logic              sdo_o,
    input logic [CODE_W-1:0] code_o,
    input logic              rise_mode,
    input link_state_e       state
);
    assert_code_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(sync_s) |=> $stable(code_o));

    assert_mode_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rise_mode |=> rise_mode);

    assert_mode_at_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(sync_s) |=> $stable(rise_mode));

    assert_sdo_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(sclk_s) |=> $stable(sdo_o));

    assert_idle_when_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sync_s |=> (state == ST_IDLE));
endmodule

bind dac_serial_link dsl_checker #(.CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .sync_s(sync_s),
    .sdo_o(sdo_o), .code_o(code_o), .rise_mode(rise_mode), .state(link_state)
);

// File: tb/sim_dac_serial_link.sv
module sim_dac_serial_link;
    localparam int CW = 12;
    localparam int H = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1;
    logic sdin = 1'b0;
    logic sync_n = 1'b1;
    logic sdo;
    logic [CW-1:0] code;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    logic [CW-1:0] exp_code = '0;
    bit rm = 1'b0;
    logic [15:0] hist = '0;

    always #5 clk = ~clk;

    dac_serial_link #(.CODE_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdin_i(sdin),
        .sync_n_i(sync_n), .sdo_o(sdo), .code_o(code)
    );

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // one bit: data valid before the active edge, inverted before the return edge
    task automatic put_bit(input logic b, input bit last_coinc);
        logic idle;
        idle = rm ? 1'b0 : 1'b1;
        sdin = b;
        hold(H);
        sclk = ~idle;
        if (last_coinc) sync_n = 1'b1;
        hold(H);
        sdin = ~b;
        hold(H);
        sclk = idle;
        hold(H);
        if (!last_coinc) hist = {hist[14:0], b};
        chk("R6 sdo", sdo, hist[15]);
    endtask

    task automatic send(input logic [31:0] w, input int n, input bit coinc, input string tag);
        int taken;
        logic [15:0] f;
        sclk = rm ? 1'b0 : 1'b1;
        sync_n = 1'b0;
        hold(H);
        for (int i = n - 1; i >= 0; i--) put_bit(w[i], coinc && i == 0);
        sync_n = 1'b1;
        hold(5);
        taken = coinc ? n - 1 : n;
        if (taken >= 16) begin
            f = w[15:0];
            if (f[15:14] == 2'b11) rm = 1'b1;
            else exp_code = CW'(f[13:0] >> (14 - CW));
        end
        chk(tag, code, exp_code);
        sclk = rm ? 1'b0 : 1'b1;
        hold(H);
    endtask

    initial begin
        logic [13:0] d;
        hold(5);
        rst_n = 1'b1;
        hold(3);
        chk("R1 code after reset", code, 0);
        chk("R1 sdo after reset", sdo, 0);

        // R1: first frame captured on the falling edge
        send(32'h3FFF, 16, 1'b0, "R1 falling capture");
        send(32'h0000, 16, 1'b0, "R3 zero code");
        send(32'h7FFF, 16, 1'b0, "R3 full code ctrl 01");

        // R3 R10: sweep of data and control codes 00/01/10
        for (int k = 0; k < 48; k++) begin
            d = 14'((k * 1237 + 91) % 16384);
            send({16'h0, 2'(k % 3), d}, 16, 1'b0, "R3/R10 sweep");
        end

        // R2: serial clock toggles while strobe high are ignored
        for (int k = 0; k < 6; k++) begin
            sdin = k[0];
            hold(H);
            sclk = ~sclk;
            hold(H);
        end
        sclk = 1'b1;
        hold(H);
        chk("R2 code unchanged", code, exp_code);
        chk("R2 sdo unchanged", sdo, hist[15]);

        // R7: short frame discarded
        send(32'h0155, 10, 1'b0, "R7 short frame");
        // R8: long frame keeps last 16 bits
        send(32'h000A2345, 20, 1'b0, "R8 long frame");
        // R9: 16th edge coincides with strobe rise
        send(32'h1ABC, 16, 1'b0, "R3 before coincide");
        send(32'h2F0F, 16, 1'b1, "R9 coincident edge");

        // R5: control 11 moves capture to rising edge, code held
        send(32'hC123, 16, 1'b0, "R5 edge select");
        for (int k = 0; k < 16; k++) begin
            d = 14'((k * 3001 + 7) % 16384);
            send({16'h0, 2'(k % 3), d}, 16, 1'b0, "R5 rising capture");
        end
        send(32'h0000C000, 16, 1'b0, "R5 edge select again");
        send(32'h2AAA, 16, 1'b0, "R5 still rising");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule